// File: doc/BRIEF.md
# Ethernet Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether an incoming frame is kept, based only on its 48-bit destination address. When the MAC has collected the address it raises a one-cycle strobe. The filter computes a CRC-32 over the six address bytes, turns the upper CRC bits into a slot number, and looks that slot up in one of two software-written hash tables. Addresses with the group bit set use the group table, and all other addresses use the individual table.

A three-bit receive mode register combines with the lookup result. Promiscuous mode accepts every frame. All-multicast mode accepts every group frame. Hash-match mode accepts a frame only when its slot bit is set. Software is expected to choose all-multicast when its multicast list has more entries than the table has slots.

The table size is fixed at build time. The small build has 64 slots held in four 16-bit registers per table. The large build has 256 slots held in eight 32-bit registers per table. The register window moves with the build. A word-addressed write/read port reaches the mode register and both tables. Exactly one of two pulses, accept or reject, reports the decision a fixed two cycles after the strobe.

Top module: `mcast_hash_filter`

## Requirements
- R1: After a synchronous active-low reset, the mode register and every table register read zero, and no accept or reject pulse appears until an address strobe is given.
- R2: The slot is (SLOTS-1) minus the top log2(SLOTS) bits of a CRC-32. SLOTS is 64 in the small build and 256 in the large build. The CRC uses polynomial 0x04C11DB7 and starts at all ones. Bytes are fed in the order da[47:40], da[39:32], and so on down to da[7:0], each byte least significant bit first. The CRC result is not inverted.
- R3: A slot lives in table register slot>>4 (small build) or slot>>5 (large build). Its bit position in that register is W-1-(slot mod W), where W is 16 in the small build and 32 in the large build. Slot 0 is therefore bit 15 in the small build and bit 31 in the large build. No other bit selects that slot.
- R4: Register map, in words. The mode register is at word 4: bit 0 is promiscuous, bit 1 is all-multicast, bit 2 is hash-match enable. The other mode bits read zero. The individual table starts at word 12 in the small build and at word 32 in the large build. The group table follows it directly, after the same number of words (4 in the small build, 8 in the large build).
- R5: In the small build, writes to bits 31:16 of a table register are dropped, and those bits read zero. Words outside the map read zero, and writes to them have no effect.
- R6: With promiscuous mode set, every frame is accepted, whatever the tables hold.
- R7: With all-multicast mode set and promiscuous mode clear, every group frame (da[40]=1) is accepted. An individual frame is not accepted on this basis.
- R8: With hash-match enable set, a group frame is accepted when its slot bit is set in the group table. An individual frame is accepted when its slot bit is set in the individual table. The other table is never consulted.
- R9: A frame that no enabled mode accepts produces a reject pulse.
- R10: Each strobe produces exactly one pulse, accept or reject, lasting one cycle and appearing two clock edges after the strobe edge. Strobes on consecutive cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 6 | Word address for register write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| da_valid | input | 1 | One-cycle strobe: da holds a destination address |
| da | input | 48 | Destination address, first byte on da[47:40] |
| rx_accept | output | 1 | One-cycle pulse: frame kept |
| rx_reject | output | 1 | One-cycle pulse: frame dropped |

## Verification
Several properties are checked by assertions on every cycle:
- accept and reject are never raised together;
- every strobe is followed by a result two edges later, and no result appears without a strobe;
- promiscuous, all-multicast and the no-mode case always produce their forced outcome;
- in the small build the upper half of the read bus is always zero.

Other behaviours need the bench's scenarios, which carry their own CRC model. These are the correctness of the CRC and slot inversion, the most-significant-bit-first packing within a register, the register window for each build, and the choice between the individual and group tables. The bench shows them by setting the one predicted bit, or only a neighbouring bit, and observing the pulse.

// File: rtl/mhf_pkg.sv
// Package: shared constants and the address hash function for the
// multicast hash filter. Assumes a 48-bit address, first byte in [47:40].
package mhf_pkg;

    localparam int DA_W         = 48;
    localparam int CRC_W        = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

    // Mode register word and its bit positions
    localparam int MODE_WORD    = 4;
    localparam int MODE_W       = 3;
    localparam int MODE_PROMISC = 0;
    localparam int MODE_ALLGRP  = 1;
    localparam int MODE_HASH    = 2;

    // Position of the group flag inside the address
    localparam int GROUP_BIT    = 40;

    // CRC-32 over six bytes, each byte least significant bit first,
    // seeded with all ones, no final inversion.
    function automatic logic [CRC_W-1:0] addr_crc(input logic [DA_W-1:0] addr);
        logic [CRC_W-1:0] acc;
        logic [7:0]       octet;
        logic             feedback;
        acc = '1;
        for (int i = 0; i < DA_W / 8; i++) begin
            octet = addr[DA_W-1-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                feedback = acc[CRC_W-1] ^ octet[j];
                acc      = {acc[CRC_W-2:0], 1'b0};
                if (feedback)
                    acc = acc ^ CRC_POLY;
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/mhf_hash_stage.sv
// Module: first pipeline stage. Hashes the destination address and
// registers the slot number and the group flag with a valid bit.
// Assumes da is stable in the cycle da_valid is high.
module mhf_hash_stage
    import mhf_pkg::*;
#(
    parameter int SLOT_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 da_valid,
    input  logic [DA_W-1:0]      da,
    output logic                 stg_valid,
    output logic [SLOT_BITS-1:0] stg_slot,
    output logic                 stg_group
);
    localparam int SLOTS = 1 << SLOT_BITS;

    logic [CRC_W-1:0]     crc_c;
    logic [SLOT_BITS-1:0] top_c;
    logic                 unused_crc_low;

    // Hash the address and take the top CRC bits
    always_comb begin
        crc_c = addr_crc(da);
        top_c = crc_c[CRC_W-1 -: SLOT_BITS];
    end

    assign unused_crc_low = ^crc_c;

    // Register slot (inverted top bits), group flag and valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_valid <= 1'b0;
            stg_slot  <= '0;
            stg_group <= 1'b0;
        end else begin
            stg_valid <= da_valid;
            if (da_valid) begin
                stg_slot  <= SLOT_BITS'(SLOTS - 1) - top_c;
                stg_group <= da[GROUP_BIT];
            end
        end
    end

endmodule

// File: rtl/mhf_table_regs.sv
// Module: mode register plus individual and group hash tables, with a
// word-addressed write/read port and a combinational slot lookup.
// Assumes one write per cycle; reads are combinational on cfg_addr.
module mhf_table_regs
    import mhf_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    parameter int SLOT_BITS   = 6,
    parameter int WIDTH_SHIFT = 4,
    parameter int HASH_BASE   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [SLOT_BITS-1:0] look_slot,
    output logic                 ind_hit,
    output logic                 grp_hit,
    output logic [MODE_W-1:0]    mode
);
    localparam int REG_W  = 1 << WIDTH_SHIFT;
    localparam int REGS   = 1 << (SLOT_BITS - WIDTH_SHIFT);
    localparam int SLOTS  = 1 << SLOT_BITS;
    localparam int GRP_BASE = HASH_BASE + REGS;

    logic [REG_W-1:0]  ind_q [REGS];
    logic [REG_W-1:0]  grp_q [REGS];
    logic [SLOTS-1:0]  ind_flat;
    logic [SLOTS-1:0]  grp_flat;
    logic              unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    // Mode register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (cfg_wr && cfg_addr == ADDR_W'(MODE_WORD))
            mode <= cfg_wdata[MODE_W-1:0];
    end

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        // Individual table register write, only the used low bits kept
        always_ff @(posedge clk) begin
            if (!rst_n)
                ind_q[r] <= '0;
            else if (cfg_wr && cfg_addr == ADDR_W'(HASH_BASE + r))
                ind_q[r] <= cfg_wdata[REG_W-1:0];
        end

        // Group table register write, only the used low bits kept
        always_ff @(posedge clk) begin
            if (!rst_n)
                grp_q[r] <= '0;
            else if (cfg_wr && cfg_addr == ADDR_W'(GRP_BASE + r))
                grp_q[r] <= cfg_wdata[REG_W-1:0];
        end

        // Slot order: first slot of a register is its top used bit
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            assign ind_flat[r*REG_W + (REG_W-1-b)] = ind_q[r][b];
            assign grp_flat[r*REG_W + (REG_W-1-b)] = grp_q[r][b];
        end
    end

    // Slot lookup in both tables
    assign ind_hit = ind_flat[look_slot];
    assign grp_hit = grp_flat[look_slot];

    // Read mux: unmapped words and unused bits return zero
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == ADDR_W'(MODE_WORD))
            cfg_rdata = DATA_W'(mode);
        for (int r = 0; r < REGS; r++) begin
            if (cfg_addr == ADDR_W'(HASH_BASE + r))
                cfg_rdata = DATA_W'(ind_q[r]);
            if (cfg_addr == ADDR_W'(GRP_BASE + r))
                cfg_rdata = DATA_W'(grp_q[r]);
        end
    end

    if (REG_W < DATA_W) begin : g_narrow_chk
        // R5
        upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_rdata[DATA_W-1:REG_W] == '0);
    end

endmodule

// File: rtl/mhf_decide.sv
// Module: second pipeline stage. Combines the receive mode with the
// table hit and registers a one-cycle accept or reject pulse.
// Assumes ind_hit/grp_hit belong to the slot presented in the same cycle.
module mhf_decide
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_valid,
    input  logic              stg_group,
    input  logic              ind_hit,
    input  logic              grp_hit,
    input  logic [MODE_W-1:0] mode,
    output logic              rx_accept,
    output logic              rx_reject
);
    logic keep_c;

    // Decision: promiscuous, then all-multicast for groups, then hash match
    always_comb begin
        if (mode[MODE_PROMISC])
            keep_c = 1'b1;
        else if (stg_group)
            keep_c = mode[MODE_ALLGRP] || (mode[MODE_HASH] && grp_hit);
        else
            keep_c = mode[MODE_HASH] && ind_hit;
    end

    // Register the result pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_accept <= 1'b0;
            rx_reject <= 1'b0;
        end else begin
            rx_accept <= stg_valid && keep_c;
            rx_reject <= stg_valid && !keep_c;
        end
    end

    // R10
    acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_accept && rx_reject));

    // R6
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && mode[MODE_PROMISC]) |=> rx_accept);

    // R7
    allgrp_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && stg_group && mode[MODE_ALLGRP]) |=> rx_accept);

    // R9
    idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && mode == '0) |=> rx_reject);

endmodule

// File: rtl/mcast_hash_filter.sv
// Module: top of the receive destination-address hash filter.
// LARGE_TABLE picks the 64-slot (0) or 256-slot (1) table layout.
// Assumes da_valid is a single-cycle strobe per received address.
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int LARGE_TABLE = 0,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              da_valid,
    input  logic [DA_W-1:0]   da,
    output logic              rx_accept,
    output logic              rx_reject
);
    localparam int SLOT_BITS   = (LARGE_TABLE != 0) ? 8 : 6;
    localparam int WIDTH_SHIFT = (LARGE_TABLE != 0) ? 5 : 4;
    localparam int HASH_BASE   = (LARGE_TABLE != 0) ? 32 : 12;

    logic                 stg_valid;
    logic [SLOT_BITS-1:0] stg_slot;
    logic                 stg_group;
    logic                 ind_hit;
    logic                 grp_hit;
    logic [MODE_W-1:0]    mode;

    mhf_hash_stage #(
        .SLOT_BITS (SLOT_BITS)
    ) u_hash (
        .clk       (clk),
        .rst_n     (rst_n),
        .da_valid  (da_valid),
        .da        (da),
        .stg_valid (stg_valid),
        .stg_slot  (stg_slot),
        .stg_group (stg_group)
    );

    mhf_table_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SLOT_BITS   (SLOT_BITS),
        .WIDTH_SHIFT (WIDTH_SHIFT),
        .HASH_BASE   (HASH_BASE)
    ) u_tables (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .look_slot (stg_slot),
        .ind_hit   (ind_hit),
        .grp_hit   (grp_hit),
        .mode      (mode)
    );

    mhf_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .stg_valid (stg_valid),
        .stg_group (stg_group),
        .ind_hit   (ind_hit),
        .grp_hit   (grp_hit),
        .mode      (mode),
        .rx_accept (rx_accept),
        .rx_reject (rx_reject)
    );

    // R10
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> ##1 (rx_accept || rx_reject));

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept || rx_reject) |-> $past(da_valid, 2));

endmodule

// File: tb/test_mcast_hash_filter.sv
// Bench: directed scenarios against a small-table and a large-table build
// that share the register bus and the address input.
module test_mcast_hash_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd_s, rd_l;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        acc_s, rej_s, acc_l, rej_l;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic got_as, got_rs, got_al, got_rl;

    always #4 clk = ~clk;

    mcast_hash_filter #(.LARGE_TABLE(0)) i_mcast_hash_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_s), .da_valid(da_valid), .da(da),
        .rx_accept(acc_s), .rx_reject(rej_s));

    mcast_hash_filter #(.LARGE_TABLE(1)) i_mcast_hash_filter_lg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_l), .da_valid(da_valid), .da(da),
        .rx_accept(acc_l), .rx_reject(rej_l));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference hash: address streamed in transmit order, serial CRC
    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic in_bit = a[40 - 8*(k/8) + (k%8)];
            logic top    = r[31];
            r = r << 1;
            if (top != in_bit) r = r ^ 32'h04C1_1DB7;
        end
        return r;
    endfunction

    function automatic int ref_slot(input bit lg, input logic [47:0] a);
        int sb = lg ? 8 : 6;
        int t  = int'(ref_crc(a) >> (32 - sb));
        return ((1 << sb) - 1) - t;
    endfunction

    function automatic int ref_word(input bit lg, input bit grp, input int slot);
        int regs = lg ? 8 : 4;
        int base = lg ? 32 : 12;
        return base + (grp ? regs : 0) + (slot / (lg ? 32 : 16));
    endfunction

    function automatic logic [31:0] ref_mask(input bit lg, input int slot);
        int w = lg ? 32 : 16;
        return 32'h1 << (w - 1 - (slot % w));
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = 6'(a); cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] ds, output logic [31:0] dl);
        @(negedge clk);
        cfg_addr = 6'(a);
        #1;
        ds = rd_s; dl = rd_l;
    endtask

    task automatic clear_all();
        for (int a = 0; a < 64; a++) wr(a, 32'h0);
    endtask

    // Strobe one address and capture the pulses two edges later
    task automatic send(input logic [47:0] a);
        @(negedge clk);
        da = a; da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0;
        @(negedge clk);
        got_as = acc_s; got_rs = rej_s; got_al = acc_l; got_rl = rej_l;
    endtask

    task automatic expect_res(input string req, input bit lg, input bit acc);
        if (lg) chk(req, {30'h0, got_al, got_rl}, {30'h0, acc, !acc});
        else    chk(req, {30'h0, got_as, got_rs}, {30'h0, acc, !acc});
    endtask

    task automatic t_reset();
        logic [31:0] s, l;
        rd(4, s, l);
        chk("R1 mode reset small", s, 0);
        chk("R1 mode reset large", l, 0);
        for (int a = 12; a < 20; a++) begin
            rd(a, s, l);
            chk("R1 small table reset", s, 0);
        end
        for (int a = 32; a < 48; a++) begin
            rd(a, s, l);
            chk("R1 large table reset", l, 0);
        end
        chk("R1 no pulse after reset", {28'h0, acc_s, rej_s, acc_l, rej_l}, 0);
        send(48'h01005E0000FB);
        // R9 no mode set
        expect_res("R9 reject with no mode small", 0, 0);
        expect_res("R9 reject with no mode large", 1, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] s, l;
        wr(12, 32'hFFFF_FFFF);
        rd(12, s, l);
        chk("R5 small upper bits dropped", s, 32'h0000_FFFF);
        chk("R5 word 12 unmapped in large", l, 0);
        wr(16, 32'hA5A5_1234);
        rd(16, s, l);
        chk("R4 small group table at word 16", s, 32'h0000_1234);
        wr(32, 32'hDEAD_BEEF);
        rd(32, s, l);
        chk("R4 large table at word 32", l, 32'hDEAD_BEEF);
        chk("R5 word 32 unmapped in small", s, 0);
        wr(47, 32'h8000_0001);
        rd(47, s, l);
        chk("R4 large group table end word 47", l, 32'h8000_0001);
        wr(4, 32'hFFFF_FFFF);
        rd(4, s, l);
        chk("R4 mode reads three bits small", s, 32'h7);
        chk("R4 mode reads three bits large", l, 32'h7);
        wr(60, 32'h1234_5678);
        rd(60, s, l);
        chk("R5 unmapped word reads zero", s | l, 0);
        clear_all();
    endtask

    // Hash match for one address in one build
    task automatic t_hash(input bit lg, input logic [47:0] a);
        bit grp = a[40];
        int slot = ref_slot(lg, a);
        int word = ref_word(lg, grp, slot);
        int other = ref_word(lg, !grp, slot);
        logic [31:0] m = ref_mask(lg, slot);
        logic [31:0] nb = ref_mask(lg, slot ^ 1);
        clear_all();
        wr(4, 32'h4);
        wr(word, m);
        send(a);
        expect_res("R2 R3 R8 predicted slot bit accepts", lg, 1);
        wr(word, nb);
        send(a);
        expect_res("R3 neighbour bit alone rejects", lg, 0);
        wr(word, ~m & (lg ? 32'hFFFF_FFFF : 32'h0000_FFFF));
        send(a);
        expect_res("R3 all bits but predicted reject", lg, 0);
        wr(word, 32'h0);
        wr(other, m);
        send(a);
        expect_res("R8 other table not consulted", lg, 0);
        wr(word, m);
        wr(4, 32'h0);
        send(a);
        expect_res("R9 table hit without hash enable rejects", lg, 0);
    endtask

    task automatic t_promisc();
        clear_all();
        wr(4, 32'h1);
        send(48'h001122334455);
        expect_res("R6 promisc individual small", 0, 1);
        expect_res("R6 promisc individual large", 1, 1);
        send(48'h333300000001);
        expect_res("R6 promisc group small", 0, 1);
        expect_res("R6 promisc group large", 1, 1);
    endtask

    task automatic t_allgrp();
        clear_all();
        wr(4, 32'h2);
        send(48'hFFFFFFFFFFFF);
        expect_res("R7 all-multicast group small", 0, 1);
        expect_res("R7 all-multicast group large", 1, 1);
        send(48'h02AABBCCDDEE);
        expect_res("R7 all-multicast individual small", 0, 0);
        expect_res("R7 all-multicast individual large", 1, 0);
    endtask

    task automatic t_timing();
        logic [47:0] g = 48'h01005E0000FB;
        logic [47:0] u = 48'h001122334455;
        clear_all();
        wr(4, 32'h2);
        // R10 pulse placement for a lone strobe
        @(negedge clk); da = g; da_valid = 1'b1;
        @(negedge clk); da_valid = 1'b0;
        chk("R10 no pulse after one edge", {30'h0, acc_s, rej_s}, 0);
        @(negedge clk);
        chk("R10 pulse after two edges", {30'h0, acc_s, rej_s}, 2'b10);
        @(negedge clk);
        chk("R10 pulse lasts one cycle", {30'h0, acc_s, rej_s}, 0);
        // R10 back-to-back strobes
        @(negedge clk); da = g; da_valid = 1'b1;
        @(negedge clk); da = u;
        @(negedge clk); da_valid = 1'b0;
        chk("R10 first of pair accepted", {30'h0, acc_l, rej_l}, 2'b10);
        @(negedge clk);
        chk("R10 second of pair rejected", {30'h0, acc_l, rej_l}, 2'b01);
        @(negedge clk);
        chk("R10 no trailing pulse", {30'h0, acc_l, rej_l}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_hash(0, 48'h01005E0000FB);
        t_hash(0, 48'h333300000001);
        t_hash(0, 48'h00A0C9123456);
        t_hash(1, 48'h01005E0000FB);
        t_hash(1, 48'hFFFFFFFFFFFF);
        t_hash(1, 48'h5254AB00CD01);
        t_promisc();
        t_allgrp();
        t_timing();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule